// File: doc/BRIEF.md
# Read Data Packet Receiver

This block takes the byte stream that arrives during the data phase of a serial register read or block read and turns it into a clean payload stream. After a start request it hunts through filler bytes for a data-start tag. It then captures the packet payload and, when enabled, checks the two trailing check bytes against a CRC16 that it computes itself. It repeats this per packet until the requested byte count has been delivered. Payload bytes leave on a one-cycle valid strobe. Two sticky flags report whether the tag hunt ran out of budget or whether a checksum did not match.

A second, independent path judges the response to a write command. It takes a four-byte capture window and finds the latest response header in it, skipping over a stale header that may sit earlier in the same window. It then reports whether that header marks a successful final response. The serial shifter and the command issue logic sit outside this block.

Top module: `rdp_top`

## Requirements
- R1: In the hunt phase, a byte with upper nibble 0xF is the data-start tag. Filler bytes and the tag itself never appear on the payload output.
- R2: A register read (start_reg=1) delivers exactly 4 payload bytes and ignores start_len. If 8 bytes without a tag arrive, it sets err_tag and ends. A tag at the 8th position is still accepted.
- R3: A block read delivers start_len bytes in packets of min(remaining, PKT_BYTES). Each packet is preceded by its own tag.
- R4: In a block read, POLL_LIMIT consecutive non-tag bytes before a packet set err_tag and end the transfer.
- R5: With start_crc=1, each packet is followed by two check bytes, high byte first. The check value is CRC16 with polynomial 0x1021, MSB first, seeded 0xFFFF, over that packet's payload. A mismatch sets err_crc and ends the transfer, and no further packets are received.
- R6: With start_crc=0, the byte after a packet's last payload byte belongs to the next hunt.
- R7: err_tag and err_crc stay set until the next start, which clears them.
- R8: Bytes arriving while the block is idle produce no payload output and no done.
- R9: On wr_check, the scanner treats byte k of wr_window as bits [8k+7:8k]. It looks at indices 2, 1 and 0 in that order for the first byte with upper nibble 0xC. wr_ok is set when that byte's low nibble is 3 and byte k+1 is 0x00.
- R10: If none of indices 0 to 2 has upper nibble 0xC, wr_nostart is set and wr_ok is cleared. Both results hold until the next wr_check.
- R11: done is a single-cycle pulse that follows the last payload byte, the last check byte or an error. busy is low while done is high.
- R12: After reset, busy, done, out_valid, err_tag, err_crc, wr_done, wr_ok and wr_nostart are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new read data phase |
| start_reg | input | 1 | 1: register read (4 bytes, 8-byte window); 0: block read |
| start_crc | input | 1 | Check bytes follow each packet |
| start_len | input | LEN_W | Block read byte count |
| rx_valid | input | 1 | rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Payload byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished (pulse) |
| err_tag | output | 1 | Sticky: tag hunt budget exhausted |
| err_crc | output | 1 | Sticky: check bytes mismatch |
| wr_check | input | 1 | Evaluate wr_window |
| wr_window | input | 32 | Four captured write-response bytes |
| wr_done | output | 1 | Scanner result valid (pulse) |
| wr_ok | output | 1 | Final response with zero status found |
| wr_nostart | output | 1 | No response header in indices 0 to 2 |

## Verification
A wrong remaining count or packet count shows up as early as the first packet boundary. The payload stream is cut short or runs long, and done comes in the wrong cycle. A corrupted checksum register shows up only at the check bytes of a packet, as a false err_crc. A hunt counter that is off by one surfaces only when the filler run hits the window edge, so the bench places tags at exactly 8 and 99 fillers and the errors at exactly 8 and 100. Scanner priority faults need windows that hold two headers, and they show up one cycle after wr_check.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_DATA, ST_CRCH, ST_CRCL
  } rd_state_e;

  localparam logic [3:0] TAG_NIB    = 4'hF;
  localparam logic [3:0] RSP_NIB    = 4'hC;
  localparam logic [3:0] RSP_FINAL  = 4'h3;
  localparam int         REG_BYTES  = 4;
  localparam int         REG_WINDOW = 8;

  function automatic logic is_tag(input logic [7:0] b);
    return b[7:4] == TAG_NIB;
  endfunction

  // one byte of CRC16, polynomial 0x1021, MSB first
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/rdp_crc16.sv
module rdp_crc16 (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import rdp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= 16'hFFFF;
    else if (en)    crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/rdp_rx_ctrl.sv
module rdp_rx_ctrl #(
  parameter int PKT_BYTES  = 8192,
  parameter int POLL_LIMIT = 100,
  parameter int LEN_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_reg,
  input  logic             start_crc,
  input  logic [LEN_W-1:0] start_len,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic [15:0]      crc_val,
  output logic             crc_clr,
  output logic             crc_en,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             busy,
  output logic             done,
  output logic             err_tag,
  output logic             err_crc
);
  import rdp_pkg::*;

  localparam int HC_MAX = (POLL_LIMIT > REG_WINDOW) ? POLL_LIMIT : REG_WINDOW;
  localparam int HC_W   = $clog2(HC_MAX + 1);
  localparam logic [LEN_W-1:0] PKT_L = LEN_W'(PKT_BYTES);

  rd_state_e        state;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] pkt_left;
  logic [HC_W-1:0]  hunt_cnt;
  logic [HC_W-1:0]  hunt_last;
  logic             reg_mode;
  logic             crc_on;
  logic [7:0]       crc_hi;

  assign hunt_last = reg_mode ? HC_W'(REG_WINDOW - 1) : HC_W'(POLL_LIMIT - 1);
  assign crc_clr   = rx_valid && !start && (state == ST_HUNT);
  assign crc_en    = rx_valid && !start && (state == ST_DATA);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      remain    <= '0;
      pkt_left  <= '0;
      hunt_cnt  <= '0;
      reg_mode  <= 1'b0;
      crc_on    <= 1'b0;
      crc_hi    <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      done      <= 1'b0;
      err_tag   <= 1'b0;
      err_crc   <= 1'b0;
    end else begin
      done      <= 1'b0;
      out_valid <= 1'b0;
      if (start) begin
        err_tag  <= 1'b0;
        err_crc  <= 1'b0;
        reg_mode <= start_reg;
        crc_on   <= start_crc;
        hunt_cnt <= '0;
        remain   <= start_reg ? LEN_W'(REG_BYTES) : start_len;
        if (!start_reg && start_len == '0) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          state <= ST_HUNT;
        end
      end else if (rx_valid) begin
        unique case (state)
          ST_HUNT: begin
            if (is_tag(rx_byte)) begin
              pkt_left <= (remain > PKT_L) ? PKT_L : remain;
              hunt_cnt <= '0;
              state    <= ST_DATA;
            end else if (hunt_cnt == hunt_last) begin
              err_tag <= 1'b1;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              hunt_cnt <= hunt_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            out_valid <= 1'b1;
            out_byte  <= rx_byte;
            remain    <= remain - 1'b1;
            pkt_left  <= pkt_left - 1'b1;
            if (pkt_left == LEN_W'(1)) begin
              if (crc_on) state <= ST_CRCH;
              else if (remain == LEN_W'(1)) begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end else state <= ST_HUNT;
            end
          end
          ST_CRCH: begin
            crc_hi <= rx_byte;
            state  <= ST_CRCL;
          end
          ST_CRCL: begin
            if ({crc_hi, rx_byte} != crc_val) begin
              err_crc <= 1'b1;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end else if (remain == '0) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              state <= ST_HUNT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                                  // R11
  AST_HUNT_BUDGET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT) |-> (hunt_cnt <= hunt_last));                  // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_tag && !start) |=> err_tag);                                 // R7
  AST_OUT_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(state) == ST_DATA));                         // R8
  AST_CRC_ABORT: assert property (@(posedge clk) disable iff (rst)
    (err_crc && !start) |-> (state == ST_IDLE));                      // R5
endmodule

// File: rtl/rdp_wresp_scan.sv
module rdp_wresp_scan (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_check,
  input  logic [31:0] wr_window,
  output logic        wr_done,
  output logic        wr_ok,
  output logic        wr_nostart
);
  import rdp_pkg::*;

  logic       hit;
  logic [1:0] hit_idx;
  logic [7:0] hdr, nxt;

  // ascending loop: the highest matching index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < 3; k++) begin
      if (wr_window[8*k+4 +: 4] == RSP_NIB) begin
        hit     = 1'b1;
        hit_idx = 2'(k);
      end
    end
    hdr = wr_window[8*hit_idx +: 8];
    nxt = wr_window[8*hit_idx + 8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_done    <= 1'b0;
      wr_ok      <= 1'b0;
      wr_nostart <= 1'b0;
    end else begin
      wr_done <= wr_check;
      if (wr_check) begin
        wr_nostart <= !hit;
        wr_ok      <= hit && (hdr[3:0] == RSP_FINAL) && (nxt == 8'h00);
      end
    end
  end

  AST_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_ok && wr_nostart));                                          // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_check |=> $stable(wr_ok));                                    // R10
endmodule

// File: rtl/rdp_top.sv
module rdp_top #(
  parameter int PKT_BYTES  = 8192,
  parameter int POLL_LIMIT = 100,
  parameter int LEN_W      = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_reg,
  input  logic             start_crc,
  input  logic [LEN_W-1:0] start_len,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             busy,
  output logic             done,
  output logic             err_tag,
  output logic             err_crc,
  input  logic             wr_check,
  input  logic [31:0]      wr_window,
  output logic             wr_done,
  output logic             wr_ok,
  output logic             wr_nostart
);
  logic        crc_clr, crc_en;
  logic [15:0] crc_val;

  rdp_crc16 i_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(rx_byte), .crc(crc_val)
  );

  rdp_rx_ctrl #(.PKT_BYTES(PKT_BYTES), .POLL_LIMIT(POLL_LIMIT), .LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_reg(start_reg), .start_crc(start_crc),
    .start_len(start_len), .rx_valid(rx_valid), .rx_byte(rx_byte), .crc_val(crc_val),
    .crc_clr(crc_clr), .crc_en(crc_en), .out_valid(out_valid), .out_byte(out_byte),
    .busy(busy), .done(done), .err_tag(err_tag), .err_crc(err_crc)
  );

  rdp_wresp_scan i_scan (
    .clk(clk), .rst(rst), .wr_check(wr_check), .wr_window(wr_window),
    .wr_done(wr_done), .wr_ok(wr_ok), .wr_nostart(wr_nostart)
  );
endmodule

// File: tb/test_rdp_top.sv
module test_rdp_top;
  localparam int PKT = 16;
  localparam int LW  = 16;

  logic clk = 0, rst = 1;
  logic start = 0, start_reg = 0, start_crc = 0;
  logic [LW-1:0] start_len = '0;
  logic rx_valid = 0;
  logic [7:0] rx_byte = '0;
  logic out_valid, busy, done, err_tag, err_crc;
  logic [7:0] out_byte;
  logic wr_check = 0;
  logic [31:0] wr_window = '0;
  logic wr_done, wr_ok, wr_nostart;

  int checks = 0, fails = 0;
  int got_n = 0, done_n = 0;
  logic [7:0] got [0:255];

  always #2 clk = ~clk;

  rdp_top #(.PKT_BYTES(PKT), .POLL_LIMIT(100), .LEN_W(LW)) i_rdp_top (
    .clk(clk), .rst(rst), .start(start), .start_reg(start_reg), .start_crc(start_crc),
    .start_len(start_len), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .out_valid(out_valid), .out_byte(out_byte), .busy(busy), .done(done),
    .err_tag(err_tag), .err_crc(err_crc), .wr_check(wr_check), .wr_window(wr_window),
    .wr_done(wr_done), .wr_ok(wr_ok), .wr_nostart(wr_nostart)
  );

  always @(negedge clk) begin
    if (out_valid) begin got[got_n % 256] = out_byte; got_n++; end
    if (done) done_n++;
  end

  typedef struct packed {
    logic       is_reg;
    logic       crc;
    logic [15:0] len;
    logic [7:0] fill;
    logic [7:0] bad;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{1'b1, 1'b0, 16'd9,  8'd0,  8'hFF},
    '{1'b1, 1'b1, 16'd4,  8'd3,  8'hFF},
    '{1'b1, 1'b1, 16'd4,  8'd7,  8'hFF},
    '{1'b0, 1'b0, 16'd5,  8'd2,  8'hFF},
    '{1'b0, 1'b1, 16'd16, 8'd1,  8'hFF},
    '{1'b0, 1'b1, 16'd40, 8'd4,  8'hFF},
    '{1'b0, 1'b0, 16'd33, 8'd0,  8'hFF},
    '{1'b0, 1'b1, 16'd40, 8'd2,  8'd1},
    '{1'b1, 1'b1, 16'd4,  8'd1,  8'd0},
    '{1'b0, 1'b0, 16'd3,  8'd99, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[15] ^ d[7-i];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [7:0] pv(input int k, input int i);
    return 8'(i * 37 + k * 11 + 5);
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rx_valid = 0; wr_check = 0; start = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input logic r, input logic c, input int len);
    @(negedge clk);
    rx_valid = 0; start = 1; start_reg = r; start_crc = c; start_len = LW'(len);
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_case(input int k);
    vec_t v = VEC[k];
    int total, sent, exp_n, base_n, base_d, p;
    logic stop, exp_crc_err;
    total = v.is_reg ? 4 : int'(v.len);
    base_n = got_n; base_d = done_n;
    do_start(v.is_reg, v.crc, int'(v.len));
    sent = 0; exp_n = 0; p = 0; stop = 0; exp_crc_err = 0;
    while (sent < total && !stop) begin
      int n;
      logic [15:0] c;
      n = (total - sent > PKT) ? PKT : total - sent;
      for (int f = 0; f < int'(v.fill); f++) send(8'h00);
      send((total <= PKT) ? 8'hF3 : (sent == 0 ? 8'hF1 : (sent + n == total ? 8'hF3 : 8'hF2)));
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
        send(pv(k, sent + i));
        c = ref_crc(c, pv(k, sent + i));
      end
      sent += n; exp_n = sent;
      if (v.crc) begin
        if (p == int'(v.bad)) begin c = c ^ 16'h0001; stop = 1; exp_crc_err = 1; end
        send(c[15:8]); send(c[7:0]);
      end
      p++;
    end
    idle(3);
    chk($sformatf("R3 case %0d byte count", k), got_n - base_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n - base_n; i++)
      chk($sformatf("R1 case %0d byte %0d", k, i), got[(base_n + i) % 256], pv(k, i));
    chk($sformatf("R5 case %0d err_crc", k), err_crc, exp_crc_err);
    chk($sformatf("R2 case %0d err_tag", k), err_tag, 0);
    chk($sformatf("R11 case %0d done count", k), done_n - base_d, 1);
    chk($sformatf("R11 case %0d busy", k), busy, 0);
  endtask

  task automatic scan(input logic [31:0] w, input logic eok, input logic ens, input string req);
    @(negedge clk);
    wr_check = 1; wr_window = w;
    @(negedge clk);
    wr_check = 0; wr_window = 32'hC3C3_C3C3;
    chk({req, " wr_done"}, wr_done, 1);
    chk({req, " wr_ok"}, wr_ok, eok);
    chk({req, " wr_nostart"}, wr_nostart, ens);
    @(negedge clk);
    chk({req, " held"}, {wr_ok, wr_nostart}, {eok, ens});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int bn, bd;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", busy, 0); chk("R12 done", done, 0); chk("R12 out_valid", out_valid, 0);
    chk("R12 errs", {err_tag, err_crc}, 0); chk("R12 wr", {wr_done, wr_ok, wr_nostart}, 0);

    // R8 idle bytes ignored
    bn = got_n; bd = done_n;
    send(8'hF3); send(8'h12); send(8'h34); idle(2);
    chk("R8 no output while idle", got_n - bn, 0);
    chk("R8 no done while idle", done_n - bd, 0);

    for (int k = 0; k < 10; k++) run_case(k);

    // R2 window of 8 non-tag bytes expires
    bd = done_n; bn = got_n;
    do_start(1, 0, 4);
    for (int i = 0; i < 8; i++) send(8'h00);
    idle(3);
    chk("R2 err_tag after 8 fillers", err_tag, 1);
    chk("R2 no payload", got_n - bn, 0);
    chk("R11 done on tag error", done_n - bd, 1);
    send(8'hF3); idle(4);
    chk("R7 err_tag sticky", err_tag, 1);
    do_start(0, 0, 2);
    chk("R7 cleared by start", err_tag, 0);

    // R4 block poll budget
    do_start(0, 0, 2);
    for (int i = 0; i < 100; i++) send(8'h0A);
    idle(3);
    chk("R4 err_tag after poll budget", err_tag, 1);
    chk("R4 busy low", busy, 0);

    // R6 no crc: byte after payload starts the hunt (two packets)
    bn = got_n;
    do_start(0, 0, 18);
    send(8'hF1);
    for (int i = 0; i < 16; i++) send(8'(i));
    send(8'hF3); send(8'hAA); send(8'hBB); idle(3);
    chk("R6 count", got_n - bn, 18);
    chk("R6 byte after tag", got[(bn + 16) % 256], 8'hAA);

    // write-response scanner, byte k at [8k+7:8k]
    scan({8'h00, 8'hC3, 8'h00, 8'hC1}, 1, 0, "R9 stale header then final");
    scan({8'h00, 8'hC1, 8'h00, 8'hC3}, 0, 0, "R9 later header not final");
    scan({8'h00, 8'h08, 8'hC3, 8'h55}, 0, 0, "R9 nonzero status");
    scan({8'hC3, 8'h00, 8'h12, 8'h34}, 0, 1, "R10 no header");
    scan({8'h11, 8'h22, 8'h00, 8'hC3}, 1, 0, "R9 header at index 0");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule